// File: doc/BRIEF.md
# Nibble-Wide Ethernet Test Frame Transmitter

This block builds a fixed-length Ethernet test frame and sends it to a PHY over a 4-bit data path, together with a transmit-enable strobe. A one-cycle start request launches one frame. The frame begins with a preamble and a start-of-frame delimiter. A destination address and a source address follow, both captured from input ports when the frame launches. After the addresses come a parameterised number of payload bytes, all holding one fill value. The frame ends with a CRC-32 frame check sequence that the block computes nibble by nibble while the frame is being sent.

Every byte is sent as two nibbles, with the low nibble first. Address bytes go out in their written order: the most significant byte of each 48-bit address port goes first. Once a frame ends, the block stays idle for a fixed number of nibble clocks before it accepts another start. This lets a bring-up environment emit back-to-back test frames, broadcast or unicast, that a receiver can check against a known FCS.

Top module: `eth_nib_tx`

## Requirements
- R1: Each byte is sent over two consecutive clocks. Bits 3:0 go first and bits 7:4 second. For example, the source byte 0x01 appears on `txd` as 1 and then 0.
- R2: The frame opens with 7 bytes of 0x55 (14 nibbles of 5), followed by the delimiter 0xD5 (nibble 5, then D). These 8 bytes are not part of the CRC.
- R3: The 6 destination bytes come next, starting with `dst_mac[47:40]`, and then the 6 source bytes, starting with `src_mac[47:40]`.
- R4: After the source address, PAYLOAD_BYTES bytes of PAYLOAD_FILL are sent (default 48 bytes of 0x00).
- R5: The last 4 bytes carry the complement of a reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, updated 4 bits per clock) taken over the addresses and the payload. They are sent least significant byte first, low nibble first. With destination 00-01-80-3F-6C-E6, source 01-23-45-67-89-A0 and 48 zero bytes, the bytes on the wire are 75 78 03 93.
- R6: `tx_en` is high without a break for exactly 144 clocks per frame by default, from the first preamble nibble through the last FCS nibble. `txd` is 0 whenever `tx_en` is low.
- R7: When `start` is sampled high while the block is idle and the gap has elapsed, `tx_en` and the first preamble nibble appear on the next clock.
- R8: A `start` that arrives while a frame is being sent is ignored. The current frame is unchanged and no extra frame follows.
- R9: After a frame, `tx_en` stays low for at least IFG_NIBBLES clocks, and a `start` during that time is ignored. If `start` is held high, the next frame's `tx_en` rises exactly IFG_NIBBLES+1 clocks after it fell.
- R10: Both addresses are sampled on the launch clock. Changes to `dst_mac` or `src_mac` during a frame do not affect that frame.
- R11: The all-ones broadcast destination FF-FF-FF-FF-FF-FF is sent as 12 nibbles of F, with a correct FCS.
- R12: While reset is asserted and after it is released, `tx_en` and `txd` are 0 until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send one frame |
| dst_mac | input | 48 | Destination address, first byte in bits 47:40 |
| src_mac | input | 48 | Source address, first byte in bits 47:40 |
| txd | output | 4 | Transmit nibble to the PHY |
| tx_en | output | 1 | High while a frame is on `txd` |

## Verification
The end of a frame and the acceptance of the next start can land in adjacent cycles. So can the gap timer expiring and a waiting start being launched. The bench provokes both by holding `start` high across two whole frames and changing the address inputs once the first frame has launched. It then judges that the low gap is exactly IFG_NIBBLES+1 clocks, that the scoreboard matches every nibble of both frames, and that the first frame still carries the addresses sampled at its launch. Separate pulses are placed in mid-frame and inside the gap, and the bench confirms that neither one starts a frame.

// File: rtl/eth_nib_pkg.sv
package eth_nib_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;
  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam int          ADDR_BYTES    = 6;
  localparam int          FCS_BYTES     = 4;

  // Advance a reflected CRC-32 by one nibble, bit 0 of the nibble first.
  function automatic logic [31:0] crc32_nib(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 4; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_crc_nib.sv
module eth_crc_nib
  import eth_nib_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [3:0]  nib,
  output logic [31:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || init)  crc <= CRC_PRESET;
    else if (en)      crc <= crc32_nib(crc, nib);
  end

endmodule

// File: rtl/eth_gap_timer.sv
module eth_gap_timer #(
  parameter int IFG_NIBBLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic ready
);

  localparam int GW = $clog2(IFG_NIBBLES + 2);

  logic [GW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                  remain <= '0;
    else if (load)            remain <= GW'(IFG_NIBBLES);
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign ready = (remain == '0);

endmodule

// File: rtl/eth_frame_mux.sv
module eth_frame_mux
  import eth_nib_pkg::*;
#(
  parameter int          PREAMBLE_BYTES = 7,
  parameter int          PAYLOAD_BYTES  = 48,
  parameter logic [7:0]  PAYLOAD_FILL   = 8'h00,
  parameter int          IDX_W          = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [47:0]      dst,
  input  logic [47:0]      src,
  input  logic [31:0]      crc,
  output logic [3:0]       nib,
  output logic             crc_take
);

  localparam int HDR_BYTES = PREAMBLE_BYTES + 1;
  localparam int DST_B0    = HDR_BYTES;
  localparam int SRC_B0    = HDR_BYTES + ADDR_BYTES;
  localparam int DATA_NIB0 = 2 * HDR_BYTES;
  localparam int FCS_NIB0  = 2 * (HDR_BYTES + 2 * ADDR_BYTES + PAYLOAD_BYTES);

  always_comb begin
    int ni;
    int bi;
    logic [7:0] byt;
    ni       = int'(idx);
    bi       = ni >> 1;
    byt      = PAYLOAD_FILL;
    nib      = '0;
    crc_take = 1'b0;
    if (ni < FCS_NIB0) begin
      if (bi < PREAMBLE_BYTES)       byt = PRE_BYTE;
      else if (bi == PREAMBLE_BYTES) byt = SFD_BYTE;
      else begin
        for (int j = 0; j < ADDR_BYTES; j++) begin
          if (bi == DST_B0 + j) byt = dst[8*(ADDR_BYTES-1-j) +: 8];
          if (bi == SRC_B0 + j) byt = src[8*(ADDR_BYTES-1-j) +: 8];
        end
      end
      nib      = idx[0] ? byt[7:4] : byt[3:0];
      crc_take = (ni >= DATA_NIB0);
    end else begin
      for (int j = 0; j < 2 * FCS_BYTES; j++) begin
        if (ni == FCS_NIB0 + j) nib = ~crc[4*j +: 4];
      end
    end
  end

endmodule

// File: rtl/eth_nib_tx.sv
module eth_nib_tx
  import eth_nib_pkg::*;
#(
  parameter int          PREAMBLE_BYTES = 7,
  parameter int          PAYLOAD_BYTES  = 48,
  parameter logic [7:0]  PAYLOAD_FILL   = 8'h00,
  parameter int          IFG_NIBBLES    = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [47:0] dst_mac,
  input  logic [47:0] src_mac,
  output logic [3:0]  txd,
  output logic        tx_en
);

  localparam int TOTAL_BYTES = PREAMBLE_BYTES + 1 + 2 * ADDR_BYTES + PAYLOAD_BYTES + FCS_BYTES;
  localparam int TOTAL_NIB   = 2 * TOTAL_BYTES;
  localparam int CNT_W       = $clog2(TOTAL_NIB + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL_NIB - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] sel_idx;
  logic [47:0]      dst_q;
  logic [47:0]      src_q;
  logic [31:0]      crc;
  logic [3:0]       nxt_nib;
  logic             nxt_data;
  logic             gap_ok;
  logic             launch;
  logic             last;

  // Index of the nibble that will be on txd after the coming edge.
  assign sel_idx = tx_en ? cnt + 1'b1 : '0;
  assign last    = tx_en && (cnt == LAST_IDX);
  assign launch  = start && !tx_en && gap_ok;

  eth_frame_mux #(
    .PREAMBLE_BYTES (PREAMBLE_BYTES),
    .PAYLOAD_BYTES  (PAYLOAD_BYTES),
    .PAYLOAD_FILL   (PAYLOAD_FILL),
    .IDX_W          (CNT_W)
  ) u_mux (
    .idx      (sel_idx),
    .dst      (dst_q),
    .src      (src_q),
    .crc      (crc),
    .nib      (nxt_nib),
    .crc_take (nxt_data)
  );

  eth_crc_nib u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (launch),
    .en   (tx_en && !last && nxt_data),
    .nib  (nxt_nib),
    .crc  (crc)
  );

  eth_gap_timer #(
    .IFG_NIBBLES (IFG_NIBBLES)
  ) u_gap (
    .clk   (clk),
    .rst   (rst),
    .load  (last),
    .ready (gap_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en <= 1'b0;
      txd   <= '0;
      cnt   <= '0;
      dst_q <= '0;
      src_q <= '0;
    end else if (launch) begin
      tx_en <= 1'b1;
      txd   <= nxt_nib;
      cnt   <= '0;
      dst_q <= dst_mac;
      src_q <= src_mac;
    end else if (tx_en) begin
      if (last) begin
        tx_en <= 1'b0;
        txd   <= '0;
      end else begin
        txd <= nxt_nib;
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/eth_nib_tx_chk.sv
module eth_nib_tx_chk #(
  parameter int PREAMBLE_BYTES = 7,
  parameter int TOTAL_NIB      = 144,
  parameter int IFG_NIBBLES    = 24
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] txd,
  input logic       tx_en
);

  int en_run;
  int low_run;

  always_ff @(posedge clk) begin
    if (rst)        en_run <= 0;
    else if (tx_en) en_run <= en_run + 1;
    else            en_run <= 0;
  end

  always_ff @(posedge clk) begin
    if (rst)                         low_run <= IFG_NIBBLES;
    else if (tx_en)                  low_run <= 0;
    else if (low_run < IFG_NIBBLES)  low_run <= low_run + 1;
  end

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> txd == 4'h0);

  assert_run_bound_R6: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> en_run < TOTAL_NIB);

  assert_run_exact_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> en_run == TOTAL_NIB);

  assert_preamble_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_en && en_run <= 2 * PREAMBLE_BYTES) |-> txd == 4'h5);

  assert_sfd_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_en && en_run == 2 * PREAMBLE_BYTES + 1) |-> txd == 4'hD);

  assert_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> low_run >= IFG_NIBBLES);

endmodule

bind eth_nib_tx eth_nib_tx_chk #(
  .PREAMBLE_BYTES (PREAMBLE_BYTES),
  .TOTAL_NIB      (TOTAL_NIB),
  .IFG_NIBBLES    (IFG_NIBBLES)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .txd   (txd),
  .tx_en (tx_en)
);

// File: tb/tb_eth_nib_tx.sv
module tb_eth_nib_tx;

  localparam int PRE   = 7;
  localparam int PAY   = 48;
  localparam int IFG   = 24;
  localparam int DBYTES = 12 + PAY;
  localparam int TOTAL_NIB = 2 * (PRE + 1 + DBYTES + 4);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [47:0] dst_mac = '0;
  logic [47:0] src_mac = '0;
  logic [3:0]  txd;
  logic        tx_en;

  int checks = 0;
  int fails  = 0;
  int frames_started = 0;
  int frames_done = 0;
  int last_gap = 0;
  logic [3:0] exp_q[$];
  logic [3:0] cap [0:TOTAL_NIB-1];

  always #4 clk = ~clk;

  eth_nib_tx #(
    .PREAMBLE_BYTES (PRE),
    .PAYLOAD_BYTES  (PAY),
    .PAYLOAD_FILL   (8'h00),
    .IFG_NIBBLES    (IFG)
  ) dut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .dst_mac (dst_mac),
    .src_mac (src_mac),
    .txd     (txd),
    .tx_en   (tx_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: compute the expected frame and queue its nibbles.
  task automatic push_frame(input logic [47:0] d, input logic [47:0] s);
    logic [7:0]  fr [0:DBYTES-1];
    logic [31:0] c;
    for (int i = 0; i < 6; i++) begin
      fr[i]     = d[8*(5-i) +: 8];
      fr[6 + i] = s[8*(5-i) +: 8];
    end
    for (int i = 12; i < DBYTES; i++) fr[i] = 8'h00;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < DBYTES; i++) begin
      c = c ^ {24'h0, fr[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    c = ~c;
    for (int i = 0; i < PRE; i++) begin exp_q.push_back(4'h5); exp_q.push_back(4'h5); end
    exp_q.push_back(4'h5); exp_q.push_back(4'hD);
    for (int i = 0; i < DBYTES; i++) begin exp_q.push_back(fr[i][3:0]); exp_q.push_back(fr[i][7:4]); end
    for (int i = 0; i < 4; i++) begin exp_q.push_back(c[8*i +: 4]); exp_q.push_back(c[8*i+4 +: 4]); end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(tx_en === 1'b1, "R7", "tx_en one clock after start", tx_en, 1);
    check(txd === 4'h5, "R7", "first nibble", txd, 5);
  endtask

  function automatic string pos_tag(input int p);
    if (p < 2 * (PRE + 1)) return "R2";
    if (p < 2 * (PRE + 13)) return "R3";
    if (p < 2 * (PRE + 1 + DBYTES)) return "R4";
    return "R5";
  endfunction

  // Monitor: pops expected nibbles and measures enable run and gap lengths.
  bit prev_en = 1'b0;
  int run = 0;
  int low = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_en = 1'b0; run = 0; low = 0;
    end else begin
      if (tx_en) begin
        if (!prev_en) begin last_gap = low; run = 0; frames_started++; end
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "nibble with no frame expected", txd, 0);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(txd === e, pos_tag(run), $sformatf("nibble %0d", run), txd, e);
        end
        if (run < TOTAL_NIB) cap[run] = txd;
        run++;
      end else begin
        if (prev_en) begin
          check(run == TOTAL_NIB, "R6", "tx_en run length", run, TOTAL_NIB);
          frames_done++;
          low = 0;
        end
        check(txd === 4'h0, "R6", "txd while idle", txd, 0);
        low++;
      end
      prev_en = tx_en;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [3:0] fcs_exp [0:7];
    fcs_exp = '{4'h5, 4'h7, 4'h8, 4'h7, 4'h3, 4'h0, 4'h3, 4'h9};

    repeat (4) @(negedge clk);
    check(tx_en === 1'b0, "R12", "tx_en in reset", tx_en, 0);
    check(txd === 4'h0, "R12", "txd in reset", txd, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_en === 1'b0, "R12", "tx_en after reset", tx_en, 0);

    // Frame A: known test vector
    dst_mac = 48'h0001803F6CE6;
    src_mac = 48'h0123456789A0;
    push_frame(dst_mac, src_mac);
    pulse_start();
    wait (frames_done == 1);
    for (int i = 0; i < 8; i++)
      check(cap[TOTAL_NIB-8+i] === fcs_exp[i], "R5", $sformatf("known FCS nibble %0d", i),
            cap[TOTAL_NIB-8+i], fcs_exp[i]);
    check(cap[28] === 4'h1 && cap[29] === 4'h0, "R1", "low nibble of 0x01 first",
          {cap[28], cap[29]}, 8'h10);
    repeat (30) @(negedge clk);

    // Frame B: broadcast
    dst_mac = 48'hFFFFFFFFFFFF;
    src_mac = 48'h0A1B2C3D4E5F;
    push_frame(dst_mac, src_mac);
    pulse_start();
    wait (frames_done == 2);
    for (int i = 16; i < 28; i++)
      check(cap[i] === 4'hF, "R11", $sformatf("broadcast nibble %0d", i), cap[i], 4'hF);
    repeat (30) @(negedge clk);

    // Frame C: start and address changes in mid-frame
    dst_mac = 48'h102030405060;
    src_mac = 48'h00AA55CC3399;
    push_frame(dst_mac, src_mac);
    pulse_start();
    repeat (5) @(negedge clk);
    dst_mac = ~dst_mac;
    src_mac = ~src_mac;
    repeat (35) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait (frames_done == 3);
    check(frames_started == 3, "R8", "frames after mid-frame start", frames_started, 3);
    check(exp_q.size() == 0, "R10", "frame C fully matched", exp_q.size(), 0);

    // Start inside the gap is ignored
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    check(frames_started == 3, "R9", "frames after start in gap", frames_started, 3);

    // Back to back with start held high
    dst_mac = 48'h0001803F6CE6;
    src_mac = 48'h0123456789A0;
    push_frame(dst_mac, src_mac);
    push_frame(48'hFFFFFFFFFFFF, 48'h665544332211);
    @(negedge clk) start = 1'b1;
    wait (frames_started == 4);
    dst_mac = 48'hFFFFFFFFFFFF;
    src_mac = 48'h665544332211;
    wait (frames_started == 5);
    @(negedge clk) start = 1'b0;
    check(last_gap == IFG + 1, "R9", "held-start gap length", last_gap, IFG + 1);
    wait (frames_done == 5);
    check(exp_q.size() == 0, "R10", "back-to-back frames fully matched", exp_q.size(), 0);
    repeat (40) @(negedge clk);
    check(frames_started == 5, "R9", "no frame after start released", frames_started, 5);

    summary();
    $finish;
  end

endmodule